// File: doc/BRIEF.md
# Product-Term Macrocell With Expanders

This block is one logic cell of a small complex programmable device. A programmable AND plane forms product terms from the true and complement forms of a set of primary inputs. Three of those terms feed a fixed three-input OR gate. An XOR stage with a configurable polarity bit can invert the sum. A configuration bit routes either that combinational value or a registered copy of it to the cell output.

A second group of AND-plane rows, the expander rows, is not summed. Each expander output is inverted and fed back into the plane as an extra literal, in true and complement form, that the three summed terms can use. This lets the cell build sums of products of products: a function that needs more than three plain product terms can fit by factoring. The cost is a second pass through the plane. The polarity bit covers another case. When the complement of a function needs fewer terms than the function, the complement is built and then inverted.

The whole configuration loads in parallel from one wide word. Before it is accepted, the word is checked so that no expander row uses another expander's feedback. A word that fails this check is discarded, so the feedback can never close a combinational loop.

Top module: `mc_macrocell`

## Requirements
- R1: After a cycle with `rst` high, the whole configuration is cleared and the registered value is 0. `mc_out` then reads 0 for every input pattern until a new configuration loads.
- R2: Each row has a literal width of LW = 2*(N_IN+N_EXP). Input i uses fuse bit 2i (true form) and bit 2i+1 (complement form). Expander feedback j uses bits 2(N_IN+j) (true form of the inverted expander) and 2(N_IN+j)+1. When a fuse bit is 1, its literal is connected to the AND. An enabled row with no fuse bit set evaluates to 1.
- R3: Each row has an enable bit. A row whose enable is 0 yields 0 whatever its fuse bits are.
- R4: Row k occupies `cfg_data[k*LW +: LW]`. Rows 0..N_SUM-1 are summed. Rows N_SUM..N_SUM+N_EXP-1 are expanders. Row k's enable is bit `ROWS*LW + k`. An enabled row outputs the AND of its connected literals.
- R5: The pre-polarity sum is the OR of the N_SUM summed rows.
- R6: Expander j feeds back the complement of its AND result as literal N_IN+j. With the defaults, A'CD + B'CD + AB + BC' fits in three summed rows by using expanders AB and A'C (inputs A..D are `pin_in[0..3]`).
- R7: The polarity bit `cfg_data[ROWS*LW+ROWS]` inverts the sum when it is 1. With it set, AB' + AC' + AD' + A'CD is built from the three-term complement ABCD + A'D' + A'C'.
- R8: The mode bit `cfg_data[ROWS*LW+ROWS+1]` selects the output source. When it is 0, `mc_out` follows the inputs within the same cycle. When it is 1, `mc_out` shows the value captured at the previous rising edge and ignores input changes between edges.
- R9: The output register resets synchronously. A `rst` edge forces a held 1 to 0.
- R10: A word that sets any feedback-literal fuse bit in an expander row is ignored, and the previous configuration stays in effect.
- R11: A legal word presented with `cfg_load` high at a rising edge takes effect from that edge onward. `rst` has priority over `cfg_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register and configuration update on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Parallel configuration load strobe |
| cfg_data | input | CFG_W (67) | Configuration word: row fuses, row enables, polarity, output mode |
| pin_in | input | N_IN (4) | Primary logic inputs |
| mc_out | output | 1 | Macrocell output |

## Verification
The assertions take for granted that `rst` is driven to a known level from the first clock edge. They also assume that `cfg_data` and `pin_in` hold steady around each rising edge. The bench changes stimulus only on falling edges and samples one nanosecond later, so both assumptions hold throughout. The rejection and acceptance properties rely on the legality flag being a pure function of the word on `cfg_data`. The stimulus therefore presents each word for a whole cycle with the strobe.

// File: rtl/mc_pkg.sv
package mc_pkg;
    localparam int DEF_N_IN  = 4;
    localparam int DEF_N_EXP = 2;
    localparam int DEF_N_SUM = 3;

    // bit position of a literal inside one row's fuse field
    function automatic int lit_pos(input int src, input bit comp);
        return 2 * src + int'(comp);
    endfunction
endpackage

// File: rtl/mc_pterm.sv
module mc_pterm #(
    parameter int W = 8
) (
    input  logic [W-1:0] lits,
    input  logic [W-1:0] fuse,
    input  logic         en,
    output logic         hit
);
    // an open fuse passes 1; a closed fuse passes its literal
    assign hit = en & (&(~fuse | lits));
endmodule

// File: rtl/mc_fuse_check.sv
module mc_fuse_check #(
    parameter int N_IN  = 4,
    parameter int N_EXP = 2,
    parameter int N_SUM = 3,
    localparam int LW    = 2 * (N_IN + N_EXP),
    localparam int ROWS  = N_SUM + N_EXP,
    localparam int CFG_W = ROWS * LW + ROWS + 2
) (
    input  logic [CFG_W-1:0] word,
    output logic             legal
);
    logic [N_EXP-1:0] bad;

    for (genvar j = 0; j < N_EXP; j++) begin : g_row
        // feedback literals sit above the primary-input literals
        assign bad[j] = |word[(N_SUM + j) * LW + 2 * N_IN +: 2 * N_EXP];
    end

    assign legal = ~|bad;
endmodule

// File: rtl/mc_macrocell.sv
module mc_macrocell
    import mc_pkg::*;
#(
    parameter int N_IN  = DEF_N_IN,
    parameter int N_EXP = DEF_N_EXP,
    parameter int N_SUM = DEF_N_SUM,
    localparam int LW    = 2 * (N_IN + N_EXP),
    localparam int ROWS  = N_SUM + N_EXP,
    localparam int EN_B  = ROWS * LW,
    localparam int POL_B = EN_B + ROWS,
    localparam int REG_B = POL_B + 1,
    localparam int CFG_W = REG_B + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic [N_IN-1:0]  pin_in,
    output logic             mc_out
);
    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             held;
    } mc_state_t;

    mc_state_t st_d, st_q;

    logic             cfg_ok;
    logic [LW-1:0]    lits;
    logic [N_EXP-1:0] exp_hit;
    logic [N_SUM-1:0] sum_hit;
    logic             mc_val;

    mc_fuse_check #(.N_IN(N_IN), .N_EXP(N_EXP), .N_SUM(N_SUM)) chk_u (
        .word  (cfg_data),
        .legal (cfg_ok)
    );

    // literal vector: primary inputs, then inverted expander feedback
    for (genvar i = 0; i < N_IN; i++) begin : g_in
        assign lits[lit_pos(i, 1'b0)] = pin_in[i];
        assign lits[lit_pos(i, 1'b1)] = ~pin_in[i];
    end
    for (genvar j = 0; j < N_EXP; j++) begin : g_fb
        assign lits[lit_pos(N_IN + j, 1'b0)] = ~exp_hit[j];
        assign lits[lit_pos(N_IN + j, 1'b1)] = exp_hit[j];
    end

    // expander rows see only primary-input literals: no loop possible
    for (genvar j = 0; j < N_EXP; j++) begin : g_exp
        mc_pterm #(.W(2 * N_IN)) row_u (
            .lits (lits[2 * N_IN - 1:0]),
            .fuse (st_q.cfg[(N_SUM + j) * LW +: 2 * N_IN]),
            .en   (st_q.cfg[EN_B + N_SUM + j]),
            .hit  (exp_hit[j])
        );
    end

    for (genvar k = 0; k < N_SUM; k++) begin : g_sum
        mc_pterm #(.W(LW)) row_u (
            .lits (lits),
            .fuse (st_q.cfg[k * LW +: LW]),
            .en   (st_q.cfg[EN_B + k]),
            .hit  (sum_hit[k])
        );
    end

    assign mc_val = (|sum_hit) ^ st_q.cfg[POL_B];

    always_comb begin
        st_d      = st_q;
        st_d.held = mc_val;
        if (cfg_load && cfg_ok) begin
            st_d.cfg = cfg_data;
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign mc_out = st_q.cfg[REG_B] ? st_q.held : mc_val;
endmodule

// File: rtl/mc_macrocell_chk.sv
module mc_macrocell_chk #(
    parameter int N_IN  = 4,
    parameter int N_EXP = 2,
    parameter int N_SUM = 3,
    localparam int LW    = 2 * (N_IN + N_EXP),
    localparam int ROWS  = N_SUM + N_EXP,
    localparam int EN_B  = ROWS * LW,
    localparam int POL_B = EN_B + ROWS,
    localparam int REG_B = POL_B + 1,
    localparam int CFG_W = REG_B + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_load,
    input logic [CFG_W-1:0] cfg_data,
    input logic [CFG_W-1:0] cfg_q,
    input logic             cfg_ok,
    input logic             mc_val,
    input logic             mc_out
);
    logic [N_SUM-1:0] sum_en_q;
    assign sum_en_q = cfg_q[EN_B +: N_SUM];

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (mc_out == 1'b0));

    assert_no_rows_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (sum_en_q == '0 && !cfg_q[POL_B] && !cfg_q[REG_B] && !cfg_load)
            |=> (mc_out == 1'b0));

    assert_reg_delay_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[REG_B] && !cfg_load) |=> (mc_out == $past(mc_val)));

    assert_illegal_kept_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && !cfg_ok) |=> $stable(cfg_q));

    assert_load_applied_R11: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && cfg_ok) |=> (cfg_q == $past(cfg_data)));
endmodule

bind mc_macrocell mc_macrocell_chk #(.N_IN(N_IN), .N_EXP(N_EXP), .N_SUM(N_SUM)) chk_bind_i (
    .clk      (clk),
    .rst      (rst),
    .cfg_load (cfg_load),
    .cfg_data (cfg_data),
    .cfg_q    (st_q.cfg),
    .cfg_ok   (cfg_ok),
    .mc_val   (mc_val),
    .mc_out   (mc_out)
);

// File: tb/mc_macrocell_tb_top.sv
module mc_macrocell_tb_top;
    localparam int LW   = 12;
    localparam int ROWS = 5;
    localparam int ENB  = 60;
    localparam int POLB = 65;
    localparam int REGB = 66;
    localparam int CW   = 67;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_load = 1'b0;
    logic [CW-1:0] cfg_data = '0;
    logic [3:0]    pin_in = '0;
    logic          mc_out;

    int n_chk = 0;
    int n_err = 0;
    bit done = 0;

    mc_macrocell dut_i (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_data(cfg_data),
        .pin_in(pin_in), .mc_out(mc_out)
    );

    always #2 clk = ~clk;

    task automatic check(input logic act, input logic exp, input string req, input int v);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s in=%0d actual=%0b expected=%0b", req, v, act, exp);
        end
    endtask

    task automatic fuse(inout logic [CW-1:0] c, input int row, input int src, input bit comp);
        c[row * LW + 2 * src + int'(comp)] = 1'b1;
    endtask

    task automatic load(input logic [CW-1:0] c);
        @(negedge clk);
        cfg_data = c;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    function automatic logic f_exp(input int v);
        logic a, b, c, d;
        {d, c, b, a} = v[3:0];
        return (~a & c & d) | (~b & c & d) | (a & b) | (b & ~c);
    endfunction

    function automatic logic f_pol(input int v);
        logic a, b, c, d;
        {d, c, b, a} = v[3:0];
        return (a & ~b) | (a & ~c) | (a & ~d) | (~a & c & d);
    endfunction

    task automatic sweep_comb(input int kind, input string req);
        for (int v = 0; v < 16; v++) begin
            logic e;
            pin_in = v[3:0];
            #1;
            case (kind)
                0: e = 1'b0;
                1: e = 1'b1;
                2: e = v[0] & ~v[1];
                3: e = v[0] | v[1] | v[2];
                4: e = f_exp(v);
                default: e = f_pol(v);
            endcase
            check(mc_out, e, req, v);
        end
    endtask

    initial begin
        logic [CW-1:0] c, c_exp, c_pol;
        pin_in = 4'hA;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: cleared configuration gives 0 everywhere
        sweep_comb(0, "R1");

        // R2: enabled row with no fuses reads 1
        c = '0; c[ENB + 0] = 1'b1;
        load(c);
        sweep_comb(1, "R2");

        // R3: row with fuses but no enable reads 0
        c = '0; fuse(c, 0, 0, 0); fuse(c, 1, 1, 0);
        load(c);
        sweep_comb(0, "R3");

        // R4: single row A & ~B
        c = '0; fuse(c, 0, 0, 0); fuse(c, 0, 1, 1); c[ENB + 0] = 1'b1;
        load(c);
        sweep_comb(2, "R4");

        // R5: three rows A, B, C summed
        c = '0;
        fuse(c, 0, 0, 0); fuse(c, 1, 1, 0); fuse(c, 2, 2, 0);
        c[ENB +: 3] = 3'b111;
        load(c);
        sweep_comb(3, "R5");

        // R6: expanders AB (row 3) and A'C (row 4) fed back
        c_exp = '0;
        fuse(c_exp, 3, 0, 0); fuse(c_exp, 3, 1, 0);
        fuse(c_exp, 4, 0, 1); fuse(c_exp, 4, 2, 0);
        fuse(c_exp, 0, 4, 0); fuse(c_exp, 0, 2, 0); fuse(c_exp, 0, 3, 0);
        fuse(c_exp, 1, 5, 0); fuse(c_exp, 1, 1, 0);
        c_exp[ENB +: 5] = 5'b11011;
        load(c_exp);
        sweep_comb(4, "R6");

        // R7: complement in three rows, inverted
        c_pol = '0;
        for (int i = 0; i < 4; i++) fuse(c_pol, 0, i, 0);
        fuse(c_pol, 1, 0, 1); fuse(c_pol, 1, 3, 1);
        fuse(c_pol, 2, 0, 1); fuse(c_pol, 2, 2, 1);
        c_pol[ENB +: 3] = 3'b111;
        c_pol[POLB] = 1'b1;
        load(c_pol);
        sweep_comb(5, "R7");

        // R10: expander using feedback literal is rejected
        c = c_exp; fuse(c, 3, 4, 0);
        load(c);
        sweep_comb(5, "R10");

        // R11: legal word switches function at the load edge
        @(negedge clk);
        pin_in = 4'd3;
        cfg_data = c_exp;
        cfg_load = 1'b1;
        #1;
        check(mc_out, f_pol(3), "R11", 3);
        @(posedge clk);
        #1;
        check(mc_out, f_exp(3), "R11", 3);
        @(negedge clk);
        cfg_load = 1'b0;

        // R8: registered mode
        c = c_exp; c[REGB] = 1'b1;
        load(c);
        for (int v = 0; v < 16; v++) begin
            int prev;
            prev = (v + 15) % 16;
            @(negedge clk);
            pin_in = 4'(v);
            #1;
            if (v > 0) check(mc_out, f_exp(prev), "R8", v);
            @(posedge clk);
            #1;
            check(mc_out, f_exp(v), "R8", v);
        end

        // R9: synchronous reset clears a held 1
        @(negedge clk);
        pin_in = 4'd3;
        @(posedge clk);
        #1;
        check(mc_out, 1'b1, "R9", 3);
        @(negedge clk);
        rst = 1'b1;
        #1;
        check(mc_out, 1'b1, "R9", 3);
        @(posedge clk);
        #1;
        check(mc_out, 1'b0, "R9", 3);
        @(negedge clk);
        rst = 1'b0;
        sweep_comb(0, "R1");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule